// File: doc/BRIEF.md
# Processor-to-USB FIFO Bridge

This block is glue between a signal processor's asynchronous external-memory bus and the slave-FIFO port of a USB controller. The processor's chip-enable, read and write strobes, all active low, become the FIFO's read, write and output-enable strobes. Two processor address bits pick the FIFO endpoint. A 16-bit data path runs in each direction.

Endpoint select 01 is the bulk endpoint for data coming down from the host. Select 11 is the bulk endpoint for data going up to the host. Select 10 is a status address, not an endpoint. A processor read at the status address returns the FIFO empty flag, the FIFO full flag and the host's 2-bit command code, with the upper bits zero. The command codes are 00 for download, 01 for upload and 10 for processing; 11 is unused. The block also watches the controller's command-ready line and turns each rising edge into a one-cycle interrupt pulse to the processor.

Two small state machines run in the bridge clock domain, with all asynchronous flags first passed through a two-flop synchronizer.
- The edge machine has three states: `EDGE_LOW`, `EDGE_PULSE` and `EDGE_HIGH`.
  - LOW goes to PULSE when the synchronized ready line is high.
  - PULSE goes to HIGH if the line is still high, or back to LOW if it has dropped.
  - HIGH goes to LOW when the line falls.
- The guard machine has two states: `ERR_CLEAR` and `ERR_LATCHED`.
  - CLEAR goes to LATCHED when the processor attempts a blocked transfer.
  - LATCHED has no exit except reset.

Top module: `usb_fifo_bridge`

## Requirements
- R1: The FIFO read strobe and output enable go low only while chip enable and read are both low. The FIFO write strobe goes low only while chip enable and write are both low. With chip enable high, all three stay high.
- R2: `fifo_ep` always equals `proc_sel`. `fifo_dq_out` always equals `proc_dq_in`.
- R3: With `proc_sel` = 2'b10, a processor read returns {12'b0, cmd[1:0], full, empty} (full at bit 1, empty at bit 0). No FIFO read, write or output-enable strobe is asserted at this address. Flags and command code are seen two clocks after they settle.
- R4: `proc_dq_oe` is 1 only while chip enable and read are both low. A read at any address other than 2'b10 returns `fifo_dq_in` on `proc_dq_out`.
- R5: While the synchronized full flag is 1, the FIFO write strobe stays high. While the synchronized empty flag is 1, the FIFO read strobe stays high. The other flag does not block.
- R6: A blocked attempt sets `err_flag` one clock later: a write while full, or a read while empty, at a non-status address. It stays 1 until reset. Permitted transfers never set it.
- R7: A rising edge on `cmd_ready` makes `dsp_irq` high for exactly one clock, on the third clock edge after the change. Holding `cmd_ready` high produces no further pulse.
- R8: After reset, `dsp_irq` and `err_flag` are 0. With idle strobes, `proc_dq_oe` is 0 and all FIFO strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| proc_ce_n | input | 1 | Processor chip enable, active low |
| proc_rd_n | input | 1 | Processor read strobe, active low |
| proc_wr_n | input | 1 | Processor write strobe, active low |
| proc_sel | input | 2 | Processor word-address bits 3:2 |
| proc_dq_in | input | 16 | Write data from processor |
| proc_dq_out | output | 16 | Read data to processor |
| proc_dq_oe | output | 1 | Drive enable for processor data bus |
| fifo_dq_in | input | 16 | Read data from FIFO |
| fifo_dq_out | output | 16 | Write data to FIFO |
| fifo_rd_n | output | 1 | FIFO read strobe, active low |
| fifo_wr_n | output | 1 | FIFO write strobe, active low |
| fifo_oe_n | output | 1 | FIFO output enable, active low |
| fifo_ep | output | 2 | FIFO endpoint select |
| fifo_empty | input | 1 | FIFO empty flag, active high, asynchronous |
| fifo_full | input | 1 | FIFO full flag, active high, asynchronous |
| cmd_code | input | 2 | Host command code, asynchronous |
| cmd_ready | input | 1 | Host command-ready line, asynchronous |
| dsp_irq | output | 1 | One-cycle interrupt pulse to processor |
| err_flag | output | 1 | Sticky blocked-transfer error |

## Verification
The assertions check these rules on every clock:
- The FIFO strobes follow the chip-enable gating.
- A set flag always holds back the matching strobe.
- The data-bus drive enable never appears outside a read.
- The interrupt lasts exactly one clock and follows every synchronized rising edge.
- The error flag never falls once set.

Some behaviour only the bench scenarios can show:
- The status word's bit layout.
- The exact synchronizer latency.
- That a held-high ready line gives only one pulse.
- That reset clears the sticky error.
- That permitted transfers leave the error flag clear.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [1:0] {
        EDGE_LOW   = 2'd0,
        EDGE_PULSE = 2'd1,
        EDGE_HIGH  = 2'd2
    } edge_state_t;

    typedef enum logic {
        ERR_CLEAR   = 1'b0,
        ERR_LATCHED = 1'b1
    } err_state_t;

    localparam int STATUS_FLAG_BITS = 4;

endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bridge_edge_fsm.sv
module bridge_edge_fsm
    import bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_s,
    output logic pulse
);
    edge_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EDGE_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_LOW:   if (level_s) state_d = EDGE_PULSE;
            EDGE_PULSE: state_d = level_s ? EDGE_HIGH : EDGE_LOW;
            EDGE_HIGH:  if (!level_s) state_d = EDGE_LOW;
            default:    state_d = EDGE_LOW;
        endcase
    end

    always_comb begin
        pulse = (state_q == EDGE_PULSE);
    end

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    assert_irq_follows_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (level_s && !$past(level_s)) |=> pulse);
endmodule

// File: rtl/bridge_strobe_decode.sv
module bridge_strobe_decode
    import bridge_pkg::*;
#(
    parameter int          SEL_W      = 2,
    parameter logic [SEL_W-1:0] STATUS_SEL = 2'b10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             empty_s,
    input  logic             full_s,
    output logic             fifo_rd_n,
    output logic             fifo_wr_n,
    output logic             fifo_oe_n,
    output logic             is_status,
    output logic             err
);
    logic rd_req, wr_req, bad_try;
    err_state_t err_q, err_d;

    always_comb begin
        rd_req    = !ce_n && !rd_n;
        wr_req    = !ce_n && !wr_n;
        is_status = (sel == STATUS_SEL);
        fifo_rd_n = !(rd_req && !is_status && !empty_s);
        fifo_wr_n = !(wr_req && !is_status && !full_s);
        fifo_oe_n = !(rd_req && !is_status);
        bad_try   = !is_status && ((rd_req && empty_s) || (wr_req && full_s));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= ERR_CLEAR;
        else        err_q <= err_d;
    end

    always_comb begin
        err_d = err_q;
        unique case (err_q)
            ERR_CLEAR:   if (bad_try) err_d = ERR_LATCHED;
            ERR_LATCHED: err_d = ERR_LATCHED;
            default:     err_d = ERR_CLEAR;
        endcase
    end

    always_comb begin
        err = (err_q == ERR_LATCHED);
    end

    assert_rd_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_rd_n |-> (!ce_n && !rd_n));
    assert_wr_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_wr_n |-> (!ce_n && !wr_n));
    assert_no_wr_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        full_s |-> fifo_wr_n);
    assert_no_rd_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        empty_s |-> fifo_rd_n);
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/usb_fifo_bridge.sv
module usb_fifo_bridge
    import bridge_pkg::*;
#(
    parameter int               DATA_W      = 16,
    parameter int               SEL_W       = 2,
    parameter int               CMD_W       = 2,
    parameter int               SYNC_STAGES = 2,
    parameter logic [SEL_W-1:0] STATUS_SEL  = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_ce_n,
    input  logic              proc_rd_n,
    input  logic              proc_wr_n,
    input  logic [SEL_W-1:0]  proc_sel,
    input  logic [DATA_W-1:0] proc_dq_in,
    output logic [DATA_W-1:0] proc_dq_out,
    output logic              proc_dq_oe,
    input  logic [DATA_W-1:0] fifo_dq_in,
    output logic [DATA_W-1:0] fifo_dq_out,
    output logic              fifo_rd_n,
    output logic              fifo_wr_n,
    output logic              fifo_oe_n,
    output logic [SEL_W-1:0]  fifo_ep,
    input  logic              fifo_empty,
    input  logic              fifo_full,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic              cmd_ready,
    output logic              dsp_irq,
    output logic              err_flag
);
    localparam int SYNC_W = CMD_W + 3;
    localparam int PAD_W  = DATA_W - CMD_W - 2;

    logic [SYNC_W-1:0] raw_in, sync_out;
    logic              ready_s, full_s, empty_s, is_status;
    logic [CMD_W-1:0]  cmd_s;
    logic [DATA_W-1:0] status_word;

    assign raw_in = {cmd_ready, cmd_code, fifo_full, fifo_empty};
    assign {ready_s, cmd_s, full_s, empty_s} = sync_out;

    bridge_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
    );

    bridge_edge_fsm u_edge (
        .clk(clk), .rst_n(rst_n), .level_s(ready_s), .pulse(dsp_irq)
    );

    bridge_strobe_decode #(.SEL_W(SEL_W), .STATUS_SEL(STATUS_SEL)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .ce_n(proc_ce_n), .rd_n(proc_rd_n), .wr_n(proc_wr_n),
        .sel(proc_sel), .empty_s(empty_s), .full_s(full_s),
        .fifo_rd_n(fifo_rd_n), .fifo_wr_n(fifo_wr_n), .fifo_oe_n(fifo_oe_n),
        .is_status(is_status), .err(err_flag)
    );

    always_comb begin
        status_word = {{PAD_W{1'b0}}, cmd_s, full_s, empty_s};
        proc_dq_oe  = !proc_ce_n && !proc_rd_n;
        proc_dq_out = is_status ? status_word : fifo_dq_in;
        fifo_dq_out = proc_dq_in;
        fifo_ep     = proc_sel;
    end

    assert_oe_read_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        proc_dq_oe |-> (!proc_ce_n && !proc_rd_n));
    assert_status_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_sel == STATUS_SEL) |-> (fifo_rd_n && fifo_wr_n && fifo_oe_n));
endmodule

// File: tb/usb_fifo_bridge_tb_top.sv
module usb_fifo_bridge_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] sel = 2'b01;
    logic [15:0] pdin = '0, fdin = '0;
    logic [15:0] pdout, fdout;
    logic pdoe, frd_n, fwr_n, foe_n, irq, err;
    logic [1:0] ep;
    logic empty = 1'b0, full = 1'b0, rdy = 1'b0;
    logic [1:0] cmd = 2'b00;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    usb_fifo_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .proc_ce_n(ce_n), .proc_rd_n(rd_n), .proc_wr_n(wr_n),
        .proc_sel(sel), .proc_dq_in(pdin), .proc_dq_out(pdout), .proc_dq_oe(pdoe),
        .fifo_dq_in(fdin), .fifo_dq_out(fdout),
        .fifo_rd_n(frd_n), .fifo_wr_n(fwr_n), .fifo_oe_n(foe_n), .fifo_ep(ep),
        .fifo_empty(empty), .fifo_full(full), .cmd_code(cmd), .cmd_ready(rdy),
        .dsp_irq(irq), .err_flag(err)
    );

    // {ce_n, rd_n, wr_n, sel[1:0], empty, full, exp_rd_n, exp_wr_n, exp_oe_n, exp_dq_oe}
    localparam logic [10:0] VEC [10] = '{
        11'b1_0_1_01_0_0_1110,
        11'b0_0_1_01_0_0_0101,
        11'b0_1_0_11_0_0_1010,
        11'b0_1_1_01_0_0_1110,
        11'b0_0_1_10_0_0_1111,
        11'b0_0_1_01_1_0_1101,
        11'b0_1_0_11_0_1_1110,
        11'b0_1_0_10_0_0_1110,
        11'b1_1_0_11_0_0_1110,
        11'b0_0_1_11_0_1_0101
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        ce_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        empty = 1'b0; full = 1'b0; rdy = 1'b0; cmd = 2'b00;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int pulses;
        do_reset();
        // R8 reset state
        #2;
        chk("R8 irq", {15'b0, irq}, 16'h0);
        chk("R8 err", {15'b0, err}, 16'h0);
        chk("R8 dq_oe", {15'b0, pdoe}, 16'h0);
        chk("R8 strobes", {13'b0, frd_n, fwr_n, foe_n}, 16'h7);

        // Table walk: R1 R4 R5 strobe decode, R2 endpoint pass-through
        fdin = 16'hA5C3;
        pdin = 16'h1234;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            idle();
            empty = VEC[i][5];
            full  = VEC[i][4];
            repeat (3) @(negedge clk);
            ce_n = VEC[i][10]; rd_n = VEC[i][9]; wr_n = VEC[i][8]; sel = VEC[i][7:6];
            #2;
            chk("R1 R5 fifo_rd_n", {15'b0, frd_n}, {15'b0, VEC[i][3]});
            chk("R1 R5 fifo_wr_n", {15'b0, fwr_n}, {15'b0, VEC[i][2]});
            chk("R1 R3 fifo_oe_n", {15'b0, foe_n}, {15'b0, VEC[i][1]});
            chk("R4 proc_dq_oe", {15'b0, pdoe}, {15'b0, VEC[i][0]});
            chk("R2 fifo_ep", {14'b0, ep}, {14'b0, VEC[i][7:6]});
            chk("R2 fifo_dq_out", fdout, 16'h1234);
        end
        @(negedge clk);
        idle();

        // R4 read data from FIFO at endpoint address
        do_reset();
        fdin = 16'h5AF0;
        ce_n = 1'b0; rd_n = 1'b0; sel = 2'b01;
        #2 chk("R4 fifo read data", pdout, 16'h5AF0);
        @(negedge clk); idle();

        // R3 status word: cmd=01, full=1, empty=0 -> 0x0006
        cmd = 2'b01; full = 1'b1; empty = 1'b0;
        repeat (3) @(negedge clk);
        ce_n = 1'b0; rd_n = 1'b0; sel = 2'b10;
        #2 chk("R3 status upload/full", pdout, 16'h0006);
        @(negedge clk); idle();
        // R3 status word: cmd=10, full=0, empty=1 -> 0x0009
        cmd = 2'b10; full = 1'b0; empty = 1'b1;
        repeat (3) @(negedge clk);
        ce_n = 1'b0; rd_n = 1'b0; sel = 2'b10;
        #2 chk("R3 status process/empty", pdout, 16'h0009);
        chk("R3 no strobe at status", {13'b0, frd_n, fwr_n, foe_n}, 16'h7);
        @(negedge clk); idle();
        // R3 latency: change cmd, one clock later still old value
        cmd = 2'b00;
        @(negedge clk);
        ce_n = 1'b0; rd_n = 1'b0;
        #2 chk("R3 sync latency old", pdout, 16'h0009);
        @(negedge clk);
        #2 chk("R3 sync latency new", pdout, 16'h0001);
        @(negedge clk); idle();
        chk("R6 status read leaves err clear", {15'b0, err}, 16'h0);

        // R7 interrupt pulse
        do_reset();
        rdy = 1'b1;
        repeat (2) @(negedge clk);
        #2 chk("R7 no early irq", {15'b0, irq}, 16'h0);
        @(negedge clk);
        #2 chk("R7 irq on third edge", {15'b0, irq}, 16'h1);
        @(negedge clk);
        #2 chk("R7 irq one cycle", {15'b0, irq}, 16'h0);
        pulses = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            #2 pulses += int'(irq);
        end
        chk("R7 held level no pulse", pulses[15:0], 16'd0);
        rdy = 1'b0;
        repeat (4) @(negedge clk);
        rdy = 1'b1;
        pulses = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            #2 pulses += int'(irq);
        end
        chk("R7 second edge one pulse", pulses[15:0], 16'd1);

        // R6 sticky error on blocked write
        do_reset();
        full = 1'b1;
        repeat (3) @(negedge clk);
        ce_n = 1'b0; wr_n = 1'b0; sel = 2'b11;
        #2 chk("R6 err not yet", {15'b0, err}, 16'h0);
        @(negedge clk);
        #2 chk("R6 err set by blocked write", {15'b0, err}, 16'h1);
        idle();
        full = 1'b0;
        repeat (5) @(negedge clk);
        #2 chk("R6 err held", {15'b0, err}, 16'h1);
        do_reset();
        #2 chk("R6 err cleared by reset", {15'b0, err}, 16'h0);

        // R6 blocked read
        empty = 1'b1;
        repeat (3) @(negedge clk);
        ce_n = 1'b0; rd_n = 1'b0; sel = 2'b01;
        @(negedge clk);
        #2 chk("R6 err set by blocked read", {15'b0, err}, 16'h1);

        // R6 permitted transfers never set error
        do_reset();
        ce_n = 1'b0; rd_n = 1'b0; sel = 2'b01;
        repeat (2) @(negedge clk);
        idle();
        @(negedge clk);
        ce_n = 1'b0; wr_n = 1'b0; sel = 2'b11;
        repeat (2) @(negedge clk);
        idle();
        #2 chk("R6 permitted transfers", {15'b0, err}, 16'h0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule